// File: doc/BRIEF.md
# Split Long Branch-with-Link Execute Unit

This unit executes the two halves of the compressed-mode long branch-with-link as two independent 16-bit instructions. The prefix half loads the link register with a PC-relative high offset. The suffix half branches to the current link register plus a small low offset, and it writes the compressed-mode return address back into the link register. Because the two halves are never paired, the suffix half can also serve on its own as an indirect call through the link register with an added offset.

The unit sits in the execute stage. It receives the instruction, its address, the link register value that the register file currently holds, and a valid strobe. One cycle later it presents a link register write, a branch request and the cycle cost of the instruction. In compressed mode a PC read returns the instruction address plus 4. Instruction bits [15:11] select the half: 5'b11110 is the prefix and 5'b11111 is the suffix.

Top module: `split_bl_exec`

## Requirements
- R1: A valid prefix (instr[15:11]=5'b11110) gives lr_we=1, br_taken=0 and lr_wdata = pc + 4 + sext({instr[10:0],12'b0}) one cycle after the strobe.
- R2: The prefix offset is a signed 23-bit value. When instr[10]=1 the added offset is negative, sign-extended to 32 bits.
- R3: A valid suffix (instr[15:11]=5'b11111) gives br_target = (lr_in + {instr[10:0],1'b0}) with bit 0 cleared. It uses the lr_in value presented with that instruction.
- R4: A valid suffix gives lr_wdata = (pc + 2) | 1.
- R5: A valid suffix gives br_taken=1 and lr_we=1 one cycle after the strobe.
- R6: A suffix needs no preceding prefix. Its result depends only on its own inputs, so it works back-to-back, after another suffix, or alone.
- R7: A valid instruction with any other value of bits [15:11] leaves lr_we, br_taken, cost_seq and cost_nseq at 0.
- R8: A prefix reports cost_seq=1 and cost_nseq=0. A suffix reports cost_seq=2 and cost_nseq=1.
- R9: When in_valid=0, every output is 0 on the next cycle.
- R10: While rst is high, lr_we, br_taken and both cost outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 16 | Compressed instruction |
| pc | input | 32 | Address of the instruction |
| lr_in | input | 32 | Current link register value |
| lr_we | output | 1 | Link register write enable |
| lr_wdata | output | 32 | Link register write data |
| br_taken | output | 1 | Branch request |
| br_target | output | 32 | Fetch address, bit 0 clear |
| cost_seq | output | 2 | Sequential cycle count |
| cost_nseq | output | 1 | Non-sequential cycle count |

## Verification
The hardest case to reach from the ports is a suffix that runs without its prefix. This includes a suffix whose link value is odd or otherwise arbitrary, and one that comes straight after another suffix. The stimulus therefore drives lr_in values that no prefix could have produced and issues several suffixes back-to-back. Negative prefix offsets are driven at the extreme field value 0x400 and at all ones. This exposes any sign-extension or shift-position error.

// File: rtl/split_bl_exec.sv
module split_bl_exec #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [15:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] lr_in,
  output logic            lr_we,
  output logic [XLEN-1:0] lr_wdata,
  output logic            br_taken,
  output logic [XLEN-1:0] br_target,
  output logic [1:0]      cost_seq,
  output logic            cost_nseq
);
  localparam int OFFW = 11;
  localparam logic [4:0] OP_PRE = 5'b11110;
  localparam logic [4:0] OP_SUF = 5'b11111;

  logic [OFFW-1:0] off;
  logic            is_pre, is_suf;
  logic [XLEN-1:0] hi_off, lo_off, pre_lr, suf_lr, suf_tgt;

  assign off    = instr[OFFW-1:0];
  assign is_pre = in_valid && instr[15:11] == OP_PRE;
  assign is_suf = in_valid && instr[15:11] == OP_SUF;
  assign hi_off = {{(XLEN-OFFW-12){off[OFFW-1]}}, off, 12'b0};
  assign lo_off = {{(XLEN-OFFW-1){1'b0}}, off, 1'b0};
  assign pre_lr = pc + XLEN'(4) + hi_off;
  assign suf_lr = (pc + XLEN'(2)) | XLEN'(1);
  assign suf_tgt = (lr_in + lo_off) & ~XLEN'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_we     <= 1'b0;
      lr_wdata  <= '0;
      br_taken  <= 1'b0;
      br_target <= '0;
      cost_seq  <= 2'd0;
      cost_nseq <= 1'b0;
    end else begin
      lr_we     <= is_pre || is_suf;
      lr_wdata  <= is_pre ? pre_lr : (is_suf ? suf_lr : '0);
      br_taken  <= is_suf;
      br_target <= is_suf ? suf_tgt : '0;
      cost_seq  <= is_suf ? 2'd2 : (is_pre ? 2'd1 : 2'd0);
      cost_nseq <= is_suf;
    end
  end
endmodule

module split_bl_exec_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [15:0]     instr,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] lr_in,
  input logic            lr_we,
  input logic [XLEN-1:0] lr_wdata,
  input logic            br_taken,
  input logic [XLEN-1:0] br_target,
  input logic [1:0]      cost_seq,
  input logic            cost_nseq
);
  // R1
  pre_writes_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:11] == 5'b11110) |=> (lr_we && !br_taken));
  // R5
  suf_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:11] == 5'b11111) |=> (lr_we && br_taken));
  // R4
  suf_thumb_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:11] == 5'b11111) |=> lr_wdata[0]);
  // R3
  target_even_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> !br_target[0]);
  // R7
  other_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:12] != 4'hF) |=> (!lr_we && !br_taken && cost_seq == 2'd0));
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!lr_we && !br_taken && !cost_nseq));
  // R8
  cost_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (cost_seq == 2'd2 && cost_nseq));
endmodule

bind split_bl_exec split_bl_exec_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/split_bl_exec_tb.sv
module split_bl_exec_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] pc = '0, lr_in = '0;
  logic lr_we, br_taken, cost_nseq;
  logic [31:0] lr_wdata, br_target;
  logic [1:0] cost_seq;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [68:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  split_bl_exec u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .pc(pc), .lr_in(lr_in), .lr_we(lr_we), .lr_wdata(lr_wdata), .br_taken(br_taken),
    .br_target(br_target), .cost_seq(cost_seq), .cost_nseq(cost_nseq));

  function automatic logic [68:0] model(input logic v, input logic [15:0] ins,
                                        input logic [31:0] a, input logic [31:0] lr);
    logic [31:0] off32;
    if (!v) return '0;
    if (ins[15:11] == 5'b11110) begin
      off32 = 32'($signed(ins[10:0])) << 12;
      return {1'b1, a + 32'd4 + off32, 1'b0, 32'd0, 2'd1, 1'b0};
    end
    if (ins[15:11] == 5'b11111)
      return {1'b1, (a + 32'd2) | 32'd1, 1'b1,
              (lr + {20'd0, ins[10:0], 1'b0}) & 32'hFFFF_FFFE, 2'd2, 1'b1};
    return '0;
  endfunction

  task automatic drive(input logic v, input logic [15:0] ins, input logic [31:0] a,
                       input logic [31:0] lr, input string tag);
    @(negedge clk);
    in_valid = v; instr = ins; pc = a; lr_in = lr;
    exp_q.push_back(model(v, ins, a, lr));
    tag_q.push_back(tag);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always begin
    @(posedge clk); #5;
    if (exp_q.size() > 0) begin
      logic [68:0] e, act;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      act = {lr_we, lr_wdata, br_taken, br_target, cost_seq, cost_nseq};
      checks++;
      if (act !== e) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", t, act, e);
      end
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    in_valid = 1'b1; instr = 16'hF123; pc = 32'h100;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (lr_we || br_taken || cost_seq != 0 || cost_nseq) begin
      failures++;
      $display("FAIL R10 actual=%b%b%0d%b expected=0000", lr_we, br_taken, cost_seq, cost_nseq);
    end
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
    drive(1, 16'hF123, 32'h0000_1000, 32'h0, "R1 prefix positive");
    drive(1, 16'hF7FF, 32'h0000_8000, 32'h0, "R2 prefix all ones");
    drive(1, 16'hF400, 32'h0040_0000, 32'h0, "R2 prefix most negative");
    drive(1, 16'hF3FF, 32'h0000_0000, 32'h0, "R1 prefix max positive");
    drive(1, 16'hF810, 32'h0000_2000, 32'h0012_4004, "R3 R4 R5 suffix");
    drive(1, 16'hF805, 32'h0000_2002, 32'h0000_3001, "R3 odd lr cleared");
    drive(1, 16'hFFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R6 suffix alone wrap");
    drive(1, 16'hF800, 32'h0000_2004, 32'h0800_0001, "R6 back-to-back suffix");
    drive(1, 16'hE000, 32'h0000_2006, 32'h1234_5678, "R7 other opcode");
    drive(1, 16'h4770, 32'h0000_2008, 32'h1234_5678, "R7 other opcode 2");
    drive(0, 16'hF801, 32'h0000_200A, 32'h1234_5678, "R9 strobe low");
    drive(1, 16'hF000, 32'h0000_3000, 32'h0, "R8 prefix cost");
    drive(1, 16'hF802, 32'h0000_3002, 32'h0000_3004, "R8 suffix cost");
    for (int i = 0; i < 16; i++) begin
      drive(1, {5'b11110, 11'(i * 131)}, 32'(32'h0100_0000 + i * 4), 32'h0, "R1 R2 sweep");
      drive(1, {5'b11111, 11'(i * 77)}, 32'(32'h0100_0002 + i * 4), 32'(i * 32'h0101_0103), "R3 R6 sweep");
    end
    drive(0, 16'h0, 32'h0, 32'h0, "R9 idle");
    @(negedge clk); @(negedge clk);
    report();
  end
endmodule